// File: doc/BRIEF.md
# Masked Vector Element Blend Unit

This unit assembles a 512-bit destination vector from two 512-bit source vectors, one element at a time, with a per-element mask bit that chooses the source of each element. The mask does not enable writes. A set bit takes the element from the second source. A clear bit either keeps the element of the first source (merging) or writes zeros (zeroing). The elements can be bytes or 16-bit words, and the active vector length can be 128, 256 or 512 bits. Both are selected on every transaction.

An execution pipeline drives the operands, the mask and the mode inputs together with `inValid`. The blended vector shows up on `result` one clock later, marked by `outValid`. A "no mask" flag makes every active element come from the second source. Bits of the result above the active length are always zero.

Top module: `vec_blend_unit`

## Requirements
- R1: With `wordSize`=0 element j occupies result bits [8j+7:8j]. With `wordSize`=1 element j occupies bits [16j+15:16j] and uses mask bit j.
- R2: When `maskOff`=0 and mask bit j is 1, active element j of the result equals element j of `srcB`.
- R3: When `maskOff`=0, `zeroMode`=0 and mask bit j is 0, active element j equals element j of `srcA`.
- R4: When `maskOff`=0, `zeroMode`=1 and mask bit j is 0, active element j is all zeros.
- R5: When `maskOff`=1, every active element equals `srcB`, whatever `selMask` and `zeroMode` hold.
- R6: `lenSel` encodes the active length: 0 = 128 bits, 1 = 256 bits, 2 or 3 = 512 bits. Result bits from the active length up to bit 511 are zero.
- R7: Mask bits at or above the active element count (16/32/64 for bytes, 8/16/32 for words) do not affect the result.
- R8: `outValid` equals `inValid` delayed by one clock. `result` is loaded only on a cycle with `inValid`=1 and holds its value otherwise.
- R9: A synchronous active-high `rst` clears `outValid` and `result` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| srcA | input | 512 | First source vector (merging fallback) |
| srcB | input | 512 | Second source vector (selected by a set mask bit) |
| selMask | input | 64 | Per-element selector mask |
| wordSize | input | 1 | 0 = byte elements, 1 = 16-bit word elements |
| lenSel | input | 2 | Active length: 0 = 128, 1 = 256, 2/3 = 512 bits |
| zeroMode | input | 1 | 0 = merging, 1 = zeroing for clear mask bits |
| maskOff | input | 1 | 1 = no mask in use, take srcB everywhere active |
| outValid | output | 1 | Result valid, one clock after inValid |
| result | output | 512 | Registered blended vector |

## Verification
Random transactions use random operands, masks, element sizes, lengths and modes. These show whether each element comes from the correct source under each mode, and whether word lanes read the right mask bit. Directed cases cover the extremes. An all-zero mask separates merging from zeroing. An all-ones mask with zeroing on confirms that set bits still select `srcB`. With `maskOff` and a hostile mask, the unit must ignore the mask. Two runs that differ only in the mask bits above the active count must give identical results. Idle cycles carry changed operands, and `result` must hold while `outValid` drops.

// File: rtl/blend_pkg.sv
package blend_pkg;
  localparam int VEC_BITS  = 512;
  localparam int LANE_BITS = 8;
  localparam int LANE_CNT  = VEC_BITS / LANE_BITS;

  // Per-byte-lane strobes from control to datapath
  typedef struct packed {
    logic [LANE_CNT-1:0] takeB;   // lane gets srcB
    logic [LANE_CNT-1:0] keepA;   // lane gets srcA
    logic                capture; // load the result register
  } laneCtrl_t;
endpackage

// File: rtl/blend_ctrl.sv
module blend_ctrl
  import blend_pkg::*;
#(
  parameter int MASK_W = LANE_CNT
) (
  input  logic              inValid,
  input  logic [MASK_W-1:0] selMask,
  input  logic              wordSize,
  input  logic [1:0]        lenSel,
  input  logic              zeroMode,
  input  logic              maskOff,
  output laneCtrl_t         strobes
);
  localparam int CNT_W = $clog2(LANE_CNT) + 1;
  localparam int MIN_LANES = 128 / LANE_BITS;

  logic [CNT_W-1:0] activeLanes;

  always_comb begin
    unique case (lenSel)
      2'd0:    activeLanes = CNT_W'(MIN_LANES);
      2'd1:    activeLanes = CNT_W'(MIN_LANES * 2);
      default: activeLanes = CNT_W'(LANE_CNT);
    endcase
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE_ID = CNT_W'(g);
    logic laneActive, maskBit, pickB;
    assign laneActive = LANE_ID < activeLanes;
    assign maskBit    = wordSize ? selMask[g / 2] : selMask[g];
    assign pickB      = maskOff | maskBit;
    assign strobes.takeB[g] = laneActive & pickB;
    assign strobes.keepA[g] = laneActive & ~pickB & ~zeroMode;
  end

  assign strobes.capture = inValid;
endmodule

// File: rtl/blend_datapath.sv
module blend_datapath
  import blend_pkg::*;
#(
  parameter int VEC_W  = VEC_BITS,
  parameter int LANE_W = LANE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  laneCtrl_t        strobes,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] result,
  output logic             outValid
);
  localparam int LANES = VEC_W / LANE_W;

  logic [VEC_W-1:0] blended;

  for (genvar g = 0; g < LANES; g++) begin : g_mux
    always_comb begin
      if (strobes.takeB[g])
        blended[g*LANE_W +: LANE_W] = srcB[g*LANE_W +: LANE_W];
      else if (strobes.keepA[g])
        blended[g*LANE_W +: LANE_W] = srcA[g*LANE_W +: LANE_W];
      else
        blended[g*LANE_W +: LANE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) result <= blended;
    end
  end
endmodule

// File: rtl/vec_blend_unit.sv
module vec_blend_unit
  import blend_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [VEC_BITS-1:0] srcA,
  input  logic [VEC_BITS-1:0] srcB,
  input  logic [LANE_CNT-1:0] selMask,
  input  logic                wordSize,
  input  logic [1:0]          lenSel,
  input  logic                zeroMode,
  input  logic                maskOff,
  output logic                outValid,
  output logic [VEC_BITS-1:0] result
);
  laneCtrl_t strobes;

  blend_ctrl #(.MASK_W(LANE_CNT)) u_ctrl (
    .inValid(inValid), .selMask(selMask), .wordSize(wordSize),
    .lenSel(lenSel), .zeroMode(zeroMode), .maskOff(maskOff),
    .strobes(strobes)
  );

  blend_datapath #(.VEC_W(VEC_BITS), .LANE_W(LANE_BITS)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .srcA(srcA), .srcB(srcB),
    .result(result), .outValid(outValid)
  );
endmodule

// File: rtl/vec_blend_checker.sv
module vec_blend_checker (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [511:0] srcA,
  input logic [511:0] srcB,
  input logic [63:0]  selMask,
  input logic [1:0]   lenSel,
  input logic         zeroMode,
  input logic         maskOff,
  input logic         outValid,
  input logic [511:0] result
);
  p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(result)));
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));
  p_upper_128_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && lenSel == 2'd0) |=> result[511:128] == '0);
  p_upper_256_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && lenSel == 2'd1) |=> result[511:256] == '0);
  p_nomask_full_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && maskOff && lenSel[1]) |=> result == $past(srcB));
  p_merge_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && !maskOff && !zeroMode && selMask == '0 && lenSel[1])
      |=> result == $past(srcA));
  p_zero_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && !maskOff && zeroMode && selMask == '0) |=> result == '0);
  p_take_all_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && !maskOff && selMask == '1 && lenSel[1]) |=> result == $past(srcB));
endmodule

bind vec_blend_unit vec_blend_checker u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
  .selMask(selMask), .lenSel(lenSel), .zeroMode(zeroMode),
  .maskOff(maskOff), .outValid(outValid), .result(result)
);

// File: tb/vec_blend_unit_test.sv
module vec_blend_unit_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [511:0] srcA, srcB;
  logic [63:0]  selMask;
  logic         wordSize, zeroMode, maskOff;
  logic [1:0]   lenSel;
  logic         outValid;
  logic [511:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vec_blend_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .selMask(selMask), .wordSize(wordSize), .lenSel(lenSel),
    .zeroMode(zeroMode), .maskOff(maskOff), .outValid(outValid), .result(result)
  );

  // Reference model built from the requirements
  function automatic logic [511:0] refBlend(
      input logic [511:0] a, input logic [511:0] b, input logic [63:0] m,
      input logic ws, input logic [1:0] ls, input logic zm, input logic mo);
    logic [511:0] r = '0;
    int vlBits = (ls == 2'd0) ? 128 : (ls == 2'd1) ? 256 : 512;
    int ew = ws ? 16 : 8;
    for (int j = 0; j < vlBits / ew; j++) begin
      for (int k = 0; k < ew; k++) begin
        if (mo || m[j])  r[j*ew + k] = b[j*ew + k];
        else if (!zm)    r[j*ew + k] = a[j*ew + k];
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  // Drive one transaction at negedge, check after the next posedge
  task automatic run(input string req, input logic [511:0] a, input logic [511:0] b,
                     input logic [63:0] m, input logic ws, input logic [1:0] ls,
                     input logic zm, input logic mo);
    @(negedge clk);
    inValid = 1'b1; srcA = a; srcB = b; selMask = m;
    wordSize = ws; lenSel = ls; zeroMode = zm; maskOff = mo;
    @(posedge clk); #1;
    checkBit({req, " valid"}, outValid, 1'b1);
    check(req, result, refBlend(a, b, m, ws, ls, zm, mo));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] a, b, held;
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; inValid = 1'b0; srcA = '0; srcB = '0; selMask = '0;
    wordSize = 1'b0; lenSel = 2'd0; zeroMode = 1'b0; maskOff = 1'b0;
    repeat (2) @(posedge clk); #1;
    checkBit("R9 reset valid", outValid, 1'b0);
    check("R9 reset result", result, '0);
    @(negedge clk); rst = 1'b0;

    a = rand512(); b = rand512();
    // R1: byte versus word lane mapping with an alternating mask
    run("R1 bytes", a, b, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 2'd2, 1'b0, 1'b0);
    run("R1 words", a, b, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 2'd2, 1'b0, 1'b0);
    // R2: all-ones mask under zeroing still selects srcB
    run("R2 all ones", a, b, '1, 1'b0, 2'd3, 1'b1, 1'b0);
    // R3 merging / R4 zeroing with an empty mask
    run("R3 merge", a, b, '0, 1'b1, 2'd2, 1'b0, 1'b0);
    run("R4 zero", a, b, '0, 1'b0, 2'd2, 1'b1, 1'b0);
    // R5: no-mask flag overrides mask and zeroing
    run("R5 nomask", a, b, '0, 1'b0, 2'd2, 1'b1, 1'b1);
    run("R5 nomask words", a, b, 64'h1234_5678_9ABC_DEF0, 1'b1, 2'd1, 1'b0, 1'b1);
    // R6: each length encoding
    run("R6 len128", a, b, '1, 1'b0, 2'd0, 1'b0, 1'b0);
    run("R6 len256", a, b, '1, 1'b1, 2'd1, 1'b0, 1'b0);
    run("R6 len3", a, b, '1, 1'b0, 2'd3, 1'b0, 1'b0);
    // R7: mask bits beyond the active count make no difference
    run("R7 low only", a, b, 64'h0000_0000_0000_5A5A, 1'b0, 2'd0, 1'b0, 1'b0);
    run("R7 high set", a, b, 64'hFFFF_FFFF_FFFF_5A5A, 1'b0, 2'd0, 1'b0, 1'b0);
    run("R7 words high set", a, b, 64'hFFFF_FFFF_FFFF_FF3C, 1'b1, 2'd0, 1'b0, 1'b0);

    // R8: idle cycle holds result and drops valid
    held = result;
    @(negedge clk);
    inValid = 1'b0; srcA = rand512(); srcB = rand512(); selMask = '1;
    @(posedge clk); #1;
    checkBit("R8 idle valid", outValid, 1'b0);
    check("R8 hold", result, held);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] m;
      m = {$urandom, $urandom};
      run("R2/R3/R4 random", rand512(), rand512(), m, 1'($urandom), 2'($urandom),
          1'($urandom), (($urandom % 8) == 0));
    end

    // R9: reset after activity
    @(negedge clk); inValid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    checkBit("R9 late reset valid", outValid, 1'b0);
    check("R9 late reset result", result, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule